// File: doc/BRIEF.md
# Ethernet ARP/UDP Receive Classifier

This block sits behind a receive MAC that has already stripped the preamble and start delimiter. It accepts the frame one byte per accepted cycle, marked by valid, start and end flags. Using fixed header offsets, it sorts each frame into one of three classes: an ARP request, a UDP datagram addressed to the configured local IP address and port, or neither. Frames in the third class are dropped.

For an ARP request, the block raises a one-cycle pulse. At the same moment it presents the requester's hardware and protocol addresses, so that reply logic can answer. For a matching UDP datagram, the payload bytes go into an internal byte FIFO. The FIFO keeps a separate committed write pointer, so a datagram becomes visible to the reader only once it has been received completely and correctly. At that point the block pulses a completion flag and reports the payload length. A frame that ends early, carries a bad length, is cut off by a new start flag, or does not fit in the FIFO is rolled back as though it never arrived. Options in the IP header, fragments, checksums and the frame check sequence are not examined.

Top module: `eth_rx_classifier`

## Requirements
- R1: A frame is an ARP request when bytes 0-5 are all 0xFF, bytes 12-13 hold 0x0806, and bytes 20-21 hold 0x0001. Byte 0 is the byte flagged as start. For such a frame, `arp_req` is high for exactly one cycle, starting the cycle after byte 31 is accepted.
- R2: When `arp_req` rises, `peer_mac` holds bytes 22-27 (byte 22 in bits 47:40) and `peer_ip` holds bytes 28-31 (byte 28 in bits 31:24). Both outputs keep their value in every other cycle.
- R3: When any one of the R1 checks fails, `arp_req` stays low and `peer_mac` and `peer_ip` stay unchanged.
- R4: A frame is accepted as UDP only when all of the following hold: bytes 12-13 hold 0x0800; byte 23 holds 0x11; bytes 30-33 equal `local_ip` (byte 30 in bits 31:24); bytes 36-37 equal `local_port` (byte 36 in bits 15:8).
- R5: The payload of an accepted datagram starts at byte 42 and is readable in order. With `rd_en` high and `rd_empty` low, the next byte appears on `rd_data` one cycle later.
- R6: Bytes 38-39 hold the UDP length L. For an accepted frame whose end flag arrives after at least L-8 payload bytes, `frame_done` pulses for one cycle after the end byte, with `frame_cnt` = L-8. Bytes beyond L-8 (padding) are not stored.
- R7: A frame that fails any R4 check stores nothing and produces no `frame_done`.
- R8: A UDP frame whose end flag arrives before byte 41, or before L-8 payload bytes, or that has L < 8, stores nothing and produces no `frame_done`.
- R9: A start flag arriving while a frame is still open discards that frame's partial payload, and parsing restarts with that byte as byte 0.
- R10: When a datagram's payload would exceed the free FIFO space, the whole datagram is discarded. Previously committed bytes stay intact and readable.
- R11: After reset, `arp_req`, `frame_done`, `frame_cnt`, `peer_mac` and `peer_ip` are zero and `rd_empty` is high. Cycles with `rx_valid` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst | input | 1 | synchronous active-high reset |
| rx_data | input | 8 | received frame byte |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_sof | input | 1 | this byte is byte 0 of a frame |
| rx_eof | input | 1 | this byte is the last of a frame |
| local_ip | input | 32 | local IPv4 address |
| local_port | input | 16 | local UDP port |
| arp_req | output | 1 | one-cycle ARP request pulse |
| peer_mac | output | 48 | requester hardware address |
| peer_ip | output | 32 | requester protocol address |
| frame_done | output | 1 | one-cycle pulse: a datagram was committed |
| frame_cnt | output | 16 | payload byte count of the committed datagram |
| rd_en | input | 1 | read one payload byte |
| rd_data | output | 8 | payload byte, one cycle after rd_en |
| rd_empty | output | 1 | no committed payload left to read |

## Verification
Each result has a fixed latency after its cause. `arp_req` and the peer addresses change one clock after byte 31 is accepted. `frame_done`, `frame_cnt` and the fall of `rd_empty` come one clock after the end byte. `rd_data` follows `rd_en` by one clock. The bench drives on the falling edge and, on every following falling edge, compares both pulses against a behavioural model. That model predicts, from the byte list alone, which byte index is the last one before each pulse. Payload is checked against a queue that the model fills only for datagrams it predicts will commit, including the cases of padding, truncation, restart and a full FIFO.

// File: rtl/eth_cls_pkg.sv
package eth_cls_pkg;
  localparam int LEN_W          = 16;
  localparam int OFF_TYPE       = 12;
  localparam int OFF_ARP_OP     = 20;
  localparam int OFF_ARP_SHA    = 22;
  localparam int OFF_ARP_SPA    = 28;
  localparam int OFF_ARP_LAST   = 31;
  localparam int OFF_IP_PROTO   = 23;
  localparam int OFF_IP_DST     = 30;
  localparam int OFF_UDP_DPORT  = 36;
  localparam int OFF_UDP_LEN    = 38;
  localparam int OFF_HDR_LAST   = 41;
  localparam int OFF_PAYLOAD    = 42;
  localparam int UDP_HDR_BYTES  = 8;
  localparam logic [15:0] TYPE_ARP  = 16'h0806;
  localparam logic [15:0] TYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  PROTO_UDP = 8'h11;
endpackage

// File: rtl/eth_hdr_parser.sv
module eth_hdr_parser
  import eth_cls_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic [31:0]      local_ip,
  input  logic [15:0]      local_port,
  input  logic             fifo_full,
  output logic             arp_hit,
  output logic [47:0]      peer_mac,
  output logic [31:0]      peer_ip,
  output logic             pay_wr,
  output logic [7:0]       pay_data,
  output logic             pay_commit,
  output logic             pay_abort,
  output logic             done,
  output logic [LEN_W-1:0] done_cnt
);
  logic             in_frame, arp_ok, udp_ok;
  logic [IDX_W-1:0] idx, cur_idx;
  logic [31:0]      ci;
  logic [47:0]      mac_sh;
  logic [23:0]      ip_sh;
  logic [7:0]       len_hi;
  logic [LEN_W-1:0] pay_need, pay_got, got_run, got_next;
  logic             active, restart, arp_run, udp_run;
  logic             arp_pass, udp_chk, udp_pass, wr_want, frame_ok;

  assign active   = in_valid && (in_sof || in_frame);
  assign restart  = in_valid && in_sof && in_frame;
  assign cur_idx  = in_sof ? '0 : idx;
  assign ci       = 32'(cur_idx);
  assign arp_run  = in_sof ? 1'b1 : arp_ok;
  assign udp_run  = in_sof ? 1'b1 : udp_ok;
  assign got_run  = in_sof ? '0 : pay_got;
  assign pay_data = in_data;

  always_comb begin
    arp_pass = arp_run;
    if (ci < 6 && in_data != 8'hFF) arp_pass = 1'b0;
    case (ci)
      OFF_TYPE:       if (in_data != TYPE_ARP[15:8]) arp_pass = 1'b0;
      OFF_TYPE + 1:   if (in_data != TYPE_ARP[7:0])  arp_pass = 1'b0;
      OFF_ARP_OP:     if (in_data != 8'h00)          arp_pass = 1'b0;
      OFF_ARP_OP + 1: if (in_data != 8'h01)          arp_pass = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    udp_chk = udp_run;
    case (ci)
      OFF_TYPE:          if (in_data != TYPE_IPV4[15:8])  udp_chk = 1'b0;
      OFF_TYPE + 1:      if (in_data != TYPE_IPV4[7:0])   udp_chk = 1'b0;
      OFF_IP_PROTO:      if (in_data != PROTO_UDP)        udp_chk = 1'b0;
      OFF_IP_DST:        if (in_data != local_ip[31:24])  udp_chk = 1'b0;
      OFF_IP_DST + 1:    if (in_data != local_ip[23:16])  udp_chk = 1'b0;
      OFF_IP_DST + 2:    if (in_data != local_ip[15:8])   udp_chk = 1'b0;
      OFF_IP_DST + 3:    if (in_data != local_ip[7:0])    udp_chk = 1'b0;
      OFF_UDP_DPORT:     if (in_data != local_port[15:8]) udp_chk = 1'b0;
      OFF_UDP_DPORT + 1: if (in_data != local_port[7:0])  udp_chk = 1'b0;
      OFF_UDP_LEN + 1:   if ({len_hi, in_data} < LEN_W'(UDP_HDR_BYTES)) udp_chk = 1'b0;
      default: ;
    endcase
    wr_want  = udp_chk && (ci >= OFF_PAYLOAD) && (got_run < pay_need);
    udp_pass = udp_chk && !(wr_want && fifo_full);
  end

  assign pay_wr     = active && udp_pass && wr_want;
  assign got_next   = got_run + LEN_W'(pay_wr);
  assign frame_ok   = udp_pass && (ci >= OFF_HDR_LAST) && (got_next == pay_need);
  assign pay_commit = active && in_eof && frame_ok;
  assign pay_abort  = restart || (active && in_eof && !frame_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0; idx <= '0; arp_ok <= 1'b0; udp_ok <= 1'b0;
      mac_sh <= '0; ip_sh <= '0; len_hi <= '0; pay_need <= '0; pay_got <= '0;
      arp_hit <= 1'b0; peer_mac <= '0; peer_ip <= '0; done <= 1'b0; done_cnt <= '0;
    end else begin
      arp_hit <= 1'b0;
      done    <= 1'b0;
      if (active) begin
        in_frame <= !in_eof;
        idx      <= (&cur_idx) ? cur_idx : cur_idx + 1'b1;
        arp_ok   <= arp_pass;
        udp_ok   <= udp_pass;
        pay_got  <= got_next;
        if (ci >= OFF_ARP_SHA && ci < OFF_ARP_SPA) mac_sh <= {mac_sh[39:0], in_data};
        if (ci >= OFF_ARP_SPA && ci < OFF_ARP_LAST) ip_sh <= {ip_sh[15:0], in_data};
        if (ci == OFF_ARP_LAST && arp_pass) begin
          arp_hit  <= 1'b1;
          peer_mac <= mac_sh;
          peer_ip  <= {ip_sh, in_data};
        end
        if (ci == OFF_UDP_LEN) len_hi <= in_data;
        if (ci == OFF_UDP_LEN + 1) pay_need <= {len_hi, in_data} - LEN_W'(UDP_HDR_BYTES);
        if (pay_commit) begin
          done     <= 1'b1;
          done_cnt <= pay_need;
        end
      end
    end
  end

  assert_arp_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    arp_hit |=> !arp_hit);
  assert_commit_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(pay_commit && pay_abort));
endmodule

// File: rtl/eth_commit_fifo.sv
module eth_commit_fifo #(
  parameter int AW = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       commit,
  input  logic       abort,
  output logic       full,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_P = (AW + 1)'(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wp, wpc, rp, wp_inc;
  logic        rd_go;

  assign wp_inc = wp + (AW + 1)'(wr);
  assign full   = (wp - rp) == DEPTH_P;
  assign empty  = (wpc == rp);
  assign rd_go  = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_go) rd_data <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; wpc <= '0; rp <= '0;
    end else begin
      wp <= abort ? wpc : wp_inc;
      if (commit) wpc <= wp_inc;
      if (rd_go) rp <= rp + 1'b1;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    wr |-> !full);
  assert_commit_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (wpc - rp) <= DEPTH_P);
endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier
  import eth_cls_pkg::*;
#(
  parameter int FIFO_AW = 10,
  parameter int IDX_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [31:0]      local_ip,
  input  logic [15:0]      local_port,
  output logic             arp_req,
  output logic [47:0]      peer_mac,
  output logic [31:0]      peer_ip,
  output logic             frame_done,
  output logic [LEN_W-1:0] frame_cnt,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_empty
);
  logic       fifo_full, pay_wr, pay_commit, pay_abort;
  logic [7:0] pay_data;

  eth_hdr_parser #(.IDX_W(IDX_W)) u_parse (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_sof(rx_sof), .in_eof(rx_eof),
    .in_data(rx_data), .local_ip(local_ip), .local_port(local_port),
    .fifo_full(fifo_full), .arp_hit(arp_req), .peer_mac(peer_mac), .peer_ip(peer_ip),
    .pay_wr(pay_wr), .pay_data(pay_data), .pay_commit(pay_commit),
    .pay_abort(pay_abort), .done(frame_done), .done_cnt(frame_cnt)
  );

  eth_commit_fifo #(.AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst(rst), .wr(pay_wr), .wdata(pay_data), .commit(pay_commit),
    .abort(pay_abort), .full(fifo_full), .rd_en(rd_en), .rd_data(rd_data),
    .empty(rd_empty)
  );

  assert_peer_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !arp_req |-> ($stable(peer_mac) && $stable(peer_ip)));
  assert_done_data_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_cnt != '0) |-> !rd_empty);
endmodule

// File: tb/sim_eth_rx_classifier.sv
module sim_eth_rx_classifier;
  localparam int DEPTH = 1024;
  localparam logic [31:0] LIP   = 32'hC0A8_0A05;
  localparam logic [15:0] LPORT = 16'h1F90;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rd_en = 1'b0;
  logic arp_req, frame_done, rd_empty;
  logic [47:0] peer_mac;
  logic [31:0] peer_ip;
  logic [15:0] frame_cnt;
  logic [7:0]  rd_data;

  int checks = 0, fails = 0;
  logic [7:0] frm[$];
  logic [7:0] exp_q[$];
  logic [47:0] m_mac = '0;
  logic [31:0] m_ip = '0;
  bit exp_arp, exp_udp;
  int exp_cnt;

  always #4 clk = ~clk;

  eth_rx_classifier u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .local_ip(LIP), .local_port(LPORT), .arp_req(arp_req),
    .peer_mac(peer_mac), .peer_ip(peer_ip), .frame_done(frame_done),
    .frame_cnt(frame_cnt), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void put(input logic [63:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) frm.push_back(v[8*k +: 8]);
  endfunction

  task automatic build_arp(input bit bcast, input logic [15:0] et, input logic [15:0] op,
                           input logic [47:0] smac, input logic [31:0] sip);
    frm = {};
    put(bcast ? 48'hFFFF_FFFF_FFFF : 48'hFFFF_FFFF_FFFE, 6);
    put(48'h0211_2233_4455, 6); put(et, 2); put(16'h0001, 2); put(16'h0800, 2);
    put(8'd6, 1); put(8'd4, 1); put(op, 2); put(smac, 6); put(sip, 4);
    put(48'h0, 6); put(LIP, 4);
    while (frm.size() < 60) frm.push_back(8'h00);
  endtask

  task automatic build_udp(input logic [15:0] et, input logic [7:0] proto, input logic [31:0] dip,
                           input logic [15:0] dport, input logic [15:0] ulen, input int npay,
                           input int pad, input int seed);
    frm = {};
    put(48'h0200_0000_0001, 6); put(48'h0211_2233_4455, 6); put(et, 2);
    put(16'h4500, 2); put(ulen + 16'd20, 2); put(16'h0, 2); put(16'h4000, 2);
    put(8'h40, 1); put(proto, 1); put(16'h0, 2); put(32'hC0A8_0A64, 4); put(dip, 4);
    put(16'h3039, 2); put(dport, 2); put(ulen, 2); put(16'h0, 2);
    for (int i = 0; i < npay; i++) frm.push_back(8'((seed + 7 * i) & 255));
    for (int i = 0; i < pad; i++) frm.push_back(8'hEE);
  endtask

  // behavioural model of the classification rules
  task automatic model(input bit eof);
    int n, len;
    n = frm.size();
    exp_arp = n >= 32 && frm[0] == 8'hFF && frm[1] == 8'hFF && frm[2] == 8'hFF &&
              frm[3] == 8'hFF && frm[4] == 8'hFF && frm[5] == 8'hFF &&
              frm[12] == 8'h08 && frm[13] == 8'h06 && frm[20] == 8'h00 && frm[21] == 8'h01;
    exp_udp = 1'b0; exp_cnt = 0;
    if (eof && n >= 42) begin
      len = {frm[38], frm[39]};
      exp_udp = frm[12] == 8'h08 && frm[13] == 8'h00 && frm[23] == 8'h11 &&
                {frm[30], frm[31], frm[32], frm[33]} == LIP && {frm[36], frm[37]} == LPORT &&
                len >= 8 && (n - 42) >= (len - 8) && (exp_q.size() + len - 8) <= DEPTH;
      exp_cnt = len - 8;
    end
  endtask

  task automatic cyc_check(input int last_drv, input int n, input bit eof);
    bit dexp;
    dexp = eof && exp_udp && last_drv == n - 1;
    chk("R1/R3 arp_req", 64'(arp_req), 64'(exp_arp && last_drv == 31));
    chk("R6/R7/R8 frame_done", 64'(frame_done), 64'(dexp));
    if (dexp) chk("R6 frame_cnt", 64'(frame_cnt), 64'(exp_cnt));
  endtask

  task automatic send(input bit eof, input int gap_at);
    int n, last_drv;
    n = frm.size();
    model(eof);
    last_drv = -1;
    for (int i = 0; i < n; i++) begin
      if (i == gap_at) begin
        @(negedge clk); cyc_check(last_drv, n, eof);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'hA5; last_drv = -1;
      end
      @(negedge clk); cyc_check(last_drv, n, eof);
      rx_valid = 1'b1; rx_data = frm[i]; rx_sof = (i == 0); rx_eof = eof && (i == n - 1);
      last_drv = i;
    end
    @(negedge clk); cyc_check(last_drv, n, eof);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    @(negedge clk); cyc_check(-1, n, eof);
    if (exp_arp) begin
      m_mac = {frm[22], frm[23], frm[24], frm[25], frm[26], frm[27]};
      m_ip  = {frm[28], frm[29], frm[30], frm[31]};
    end
    if (exp_udp) for (int i = 0; i < exp_cnt; i++) exp_q.push_back(frm[42 + i]);
    chk("R2/R3 peer_mac", 64'(peer_mac), 64'(m_mac));
    chk("R2/R3 peer_ip", 64'(peer_ip), 64'(m_ip));
    chk("R7/R8 rd_empty", 64'(rd_empty), 64'(exp_q.size() == 0));
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) begin
      @(negedge clk);
      chk({tag, " rd_empty"}, 64'(rd_empty), 64'(0));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk({tag, " rd_data"}, 64'(rd_data), 64'(exp_q.pop_front()));
    end
    @(negedge clk);
    chk({tag, " rd_empty after drain"}, 64'(rd_empty), 64'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 arp_req reset", 64'(arp_req), 64'(0));
    chk("R11 frame_done reset", 64'(frame_done), 64'(0));
    chk("R11 frame_cnt reset", 64'(frame_cnt), 64'(0));
    chk("R11 peer_mac reset", 64'(peer_mac), 64'(0));
    chk("R11 peer_ip reset", 64'(peer_ip), 64'(0));
    chk("R11 rd_empty reset", 64'(rd_empty), 64'(1));
    rst = 1'b0;
    // R1 R2: valid request, with an idle gap (R11)
    build_arp(1'b1, 16'h0806, 16'h0001, 48'h0A1B_2C3D_4E5F, 32'hC0A8_0A64); send(1'b1, 10);
    // R3: each ARP check failing alone
    build_arp(1'b0, 16'h0806, 16'h0001, 48'h1111_1111_1111, 32'h0101_0101); send(1'b1, -1);
    build_arp(1'b1, 16'h0806, 16'h0002, 48'h2222_2222_2222, 32'h0202_0202); send(1'b1, -1);
    build_arp(1'b1, 16'h0800, 16'h0001, 48'h3333_3333_3333, 32'h0303_0303); send(1'b1, -1);
    build_arp(1'b1, 16'h0806, 16'h0001, 48'h6655_4433_2211, 32'h0A00_0001); send(1'b1, 40);
    // R4 R5 R6: accepted datagrams, with and without padding
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd28, 20, 0, 3); send(1'b1, 45); drain("R4/R5");
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd13, 5, 13, 90); send(1'b1, -1); drain("R6 pad");
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd8, 0, 18, 0); send(1'b1, -1); drain("R6 zero");
    // R7: one UDP check failing at a time
    build_udp(16'h0800, 8'h11, LIP, LPORT + 16'd1, 16'd18, 10, 8, 1); send(1'b1, -1);
    build_udp(16'h0800, 8'h11, LIP ^ 32'h100, LPORT, 16'd18, 10, 8, 1); send(1'b1, -1);
    build_udp(16'h0800, 8'h06, LIP, LPORT, 16'd18, 10, 8, 1); send(1'b1, -1);
    build_udp(16'h86DD, 8'h11, LIP, LPORT, 16'd18, 10, 8, 1); send(1'b1, -1);
    drain("R7");
    // R8: truncated payload, bad length, header cut short
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd38, 10, 0, 5); send(1'b1, -1);
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd4, 10, 8, 5); send(1'b1, -1);
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd18, 0, 0, 5);
    while (frm.size() > 36) void'(frm.pop_back());
    send(1'b1, -1);
    drain("R8");
    // R9: open frame cut by a new start flag
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd40, 15, 0, 200); send(1'b0, -1);
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd20, 12, 6, 77); send(1'b1, -1);
    drain("R9");
    // R10: second datagram does not fit, first stays intact
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd1008, 1000, 0, 11); send(1'b1, -1);
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd108, 100, 0, 55); send(1'b1, -1);
    drain("R10");
    build_udp(16'h0800, 8'h11, LIP, LPORT, 16'd16, 8, 10, 33); send(1'b1, -1);
    drain("R10 recover");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule